// File: doc/BRIEF.md
# Instrument status and service-request controller

This block holds the status-reporting register hierarchy of a measurement instrument. Three status groups, questionable, standard-event and operation, each latch incoming event pulses into an event register. Each group also has a host-programmable enable mask. The masked OR of every group becomes one summary bit in an 8-bit status byte. A service-request enable mask chooses which summary bits raise the service-request output. When that happens, the request-service flag is set in bit 6 of the status byte.

The host reaches the block through a small register bus with an address, a read strobe, a write strobe and a serial-poll strobe. Register addresses are 0 questionable event (read-only), 1 questionable enable, 2 standard event (cleared on read), 3 standard enable, 4 operation condition (read-only), 5 operation enable, 6 status byte (read-only) and 7 service-request enable. Read data is combinational while the read strobe or the serial-poll strobe is high. Any clearing caused by that access takes effect at the clock edge that ends the strobe cycle. All registers reset to zero.

Top module: `stat_srq_top`

## Requirements
- R1: Status byte bit 3 is 1 exactly when some questionable event bit and its matching questionable enable bit (address 1) are both 1.
- R2: A questionable event pulse sets its bit in the event register (address 0) at the next edge, and the bit then stays set. Reading address 0 returns the value and leaves it unchanged. A write to address 0 has no effect.
- R3: Operation pulses latch into the condition register (address 4) the same way. Reading it or writing it changes nothing. Status byte bit 7 is the OR of the condition bits that are enabled in the operation enable mask (address 5).
- R4: Standard event pulses latch into address 2. A read of address 2 returns the value and clears the register at the end of the read cycle. A pulse that arrives in that same cycle is kept.
- R5: The standard enable mask (address 3) reads back what was written. Status byte bit 5 is the OR of the standard event bits it enables.
- R6: When a status-byte summary bit (3, 5 or 7) is 1 and its service-request enable bit (address 7) is also 1, the request-service flag is set at the next edge. The flag shows in status byte bit 6 and drives srq_o. Enable bit 6 is ignored.
- R7: A serial-poll strobe returns the status byte with bit 6 set and clears the request-service flag at the end of the poll cycle. Summary bits 3, 5 and 7 are not changed by the poll.
- R8: A normal read of the status byte (address 6) clears nothing, including bit 6.
- R9: If the enabled condition is still present after a serial poll, the request-service flag is set again one cycle later. Once the condition is gone, it stays clear.
- R10: Status byte bits 0, 1, 2 and 4 always read 0. After reset every register reads 0 and srq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| spoll_i | input | 1 | Serial-poll strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read / poll data, zero when idle |
| ques_evt_i | input | QW | Questionable event pulses |
| std_evt_i | input | 8 | Standard event pulses |
| oper_evt_i | input | OW | Operation event pulses |
| srq_o | output | 1 | Service-request output |

## Verification
The bench builds the block with DW=16, QW=5 and OW=12. With those values the questionable and operation groups have different, non-power-of-two widths, narrower than the data bus. This shows that the zero-extension of read data and the masking of the top bits of a write work in each group. The standard group stays at 8 bits, so all three summary paths and the feedback guard on bit 6 are exercised together.

// File: rtl/stat_srq_pkg.sv
package stat_srq_pkg;
  typedef enum logic [2:0] {
    A_QEVT = 3'd0,
    A_QEN  = 3'd1,
    A_SEVT = 3'd2,
    A_SEN  = 3'd3,
    A_OCND = 3'd4,
    A_OEN  = 3'd5,
    A_STB  = 3'd6,
    A_SRE  = 3'd7
  } reg_addr_e;

  localparam int unsigned STB_W   = 8;
  localparam int unsigned STD_W   = 8;
  localparam int unsigned BIT_QD  = 3;
  localparam int unsigned BIT_ESB = 5;
  localparam int unsigned BIT_RQS = 6;
  localparam int unsigned BIT_OPR = 7;
endpackage

// File: rtl/stat_group.sv
module stat_group #(
  parameter int unsigned W      = 8,
  parameter bit          CLR_RD = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         rd_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] en_o,
  output logic         sum_o
);
  logic [W-1:0] evt_q, en_q, evt_d;
  logic         clr;

  generate
    if (CLR_RD) begin : g_clr
      assign clr = rd_i;
    end else begin : g_hold
      assign clr = 1'b0;
    end
  endgenerate

  // same-cycle event survives a clearing read
  assign evt_d = clr ? evt_i : (evt_q | evt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      en_q  <= '0;
    end else begin
      evt_q <= evt_d;
      if (en_wr_i) en_q <= en_wdata_i;
    end
  end

  assign evt_o = evt_q;
  assign en_o  = en_q;
  assign sum_o = |(evt_q & en_q);

  // R2
  evt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((evt_q & $past(evt_i)) == $past(evt_i)));

  generate
    if (CLR_RD) begin : g_clr_chk
      // R4
      rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i |=> (evt_q == $past(evt_i)));
    end else begin : g_hold_chk
      // R2
      evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
    end
  endgenerate
endmodule

// File: rtl/stb_ctrl.sv
module stb_ctrl
  import stat_srq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sum_qd_i,
  input  logic             sum_esb_i,
  input  logic             sum_opr_i,
  input  logic             sre_wr_i,
  input  logic [STB_W-1:0] sre_wdata_i,
  input  logic             spoll_i,
  output logic [STB_W-1:0] sre_o,
  output logic [STB_W-1:0] stb_o,
  output logic             rqs_o
);
  logic [STB_W-1:0] sre_q, sum_vec, req_mask;
  logic             rqs_q, req;

  always_comb begin
    sum_vec          = '0;
    sum_vec[BIT_QD]  = sum_qd_i;
    sum_vec[BIT_ESB] = sum_esb_i;
    sum_vec[BIT_OPR] = sum_opr_i;
    req_mask         = sre_q;
    req_mask[BIT_RQS] = 1'b0;  // no self-feedback
  end

  assign req = |(sum_vec & req_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sre_q <= '0;
      rqs_q <= 1'b0;
    end else begin
      if (sre_wr_i) sre_q <= sre_wdata_i;
      if (spoll_i)  rqs_q <= 1'b0;
      else if (req) rqs_q <= 1'b1;
    end
  end

  always_comb begin
    stb_o          = sum_vec;
    stb_o[BIT_RQS] = rqs_q;
  end

  assign sre_o = sre_q;
  assign rqs_o = rqs_q;

  // R6
  rqs_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && !spoll_i) |=> rqs_q);
  // R7
  poll_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spoll_i |=> !rqs_q);
  // R8
  rqs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rqs_q && !spoll_i) |=> rqs_q);
  // R10
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o[2:0] == 3'b000) && !stb_o[4]);
endmodule

// File: rtl/stat_srq_top.sv
module stat_srq_top
  import stat_srq_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned QW = 16,
  parameter int unsigned OW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          spoll_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [QW-1:0] ques_evt_i,
  input  logic [7:0]    std_evt_i,
  input  logic [OW-1:0] oper_evt_i,
  output logic          srq_o
);
  reg_addr_e        addr;
  logic [QW-1:0]    q_evt, q_en;
  logic [STD_W-1:0] s_evt, s_en;
  logic [OW-1:0]    o_evt, o_en;
  logic [STB_W-1:0] sre, stb;
  logic             q_sum, s_sum, o_sum, rqs;

  assign addr = reg_addr_e'(addr_i);

  stat_group #(.W(QW), .CLR_RD(1'b0)) i_ques (
    .clk_i, .rst_ni, .evt_i(ques_evt_i), .rd_i(rd_i && addr == A_QEVT),
    .en_wr_i(wr_i && addr == A_QEN), .en_wdata_i(wdata_i[QW-1:0]),
    .evt_o(q_evt), .en_o(q_en), .sum_o(q_sum));

  stat_group #(.W(STD_W), .CLR_RD(1'b1)) i_std (
    .clk_i, .rst_ni, .evt_i(std_evt_i), .rd_i(rd_i && addr == A_SEVT),
    .en_wr_i(wr_i && addr == A_SEN), .en_wdata_i(wdata_i[STD_W-1:0]),
    .evt_o(s_evt), .en_o(s_en), .sum_o(s_sum));

  stat_group #(.W(OW), .CLR_RD(1'b0)) i_oper (
    .clk_i, .rst_ni, .evt_i(oper_evt_i), .rd_i(rd_i && addr == A_OCND),
    .en_wr_i(wr_i && addr == A_OEN), .en_wdata_i(wdata_i[OW-1:0]),
    .evt_o(o_evt), .en_o(o_en), .sum_o(o_sum));

  stb_ctrl i_stb (
    .clk_i, .rst_ni, .sum_qd_i(q_sum), .sum_esb_i(s_sum), .sum_opr_i(o_sum),
    .sre_wr_i(wr_i && addr == A_SRE), .sre_wdata_i(wdata_i[STB_W-1:0]),
    .spoll_i, .sre_o(sre), .stb_o(stb), .rqs_o(rqs));

  always_comb begin
    rdata_o = '0;
    if (spoll_i) begin
      rdata_o = DW'(stb);
    end else if (rd_i) begin
      unique case (addr)
        A_QEVT:  rdata_o = DW'(q_evt);
        A_QEN:   rdata_o = DW'(q_en);
        A_SEVT:  rdata_o = DW'(s_evt);
        A_SEN:   rdata_o = DW'(s_en);
        A_OCND:  rdata_o = DW'(o_evt);
        A_OEN:   rdata_o = DW'(o_en);
        A_STB:   rdata_o = DW'(stb);
        default: rdata_o = DW'(sre);
      endcase
    end
  end

  assign srq_o = rqs;

  // R1
  qd_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb[BIT_QD] == |(q_evt & q_en)));
  // R7
  poll_bit6_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spoll_i && srq_o) |-> rdata_o[BIT_RQS]);
  // R7
  poll_keep_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spoll_i && !wr_i && !rd_i && ques_evt_i == '0 && oper_evt_i == '0 && std_evt_i == '0)
      |=> (stb[BIT_QD] == $past(stb[BIT_QD])) && (stb[BIT_OPR] == $past(stb[BIT_OPR])));
endmodule

// File: tb/test_stat_srq_top.sv
module test_stat_srq_top;
  localparam int unsigned DW = 16;
  localparam int unsigned QW = 5;
  localparam int unsigned OW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    addr = '0;
  logic          rd = 1'b0, wr = 1'b0, spoll = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [QW-1:0] qev = '0;
  logic [7:0]    sev = '0;
  logic [OW-1:0] oev = '0;
  logic          srq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stat_srq_top #(.DW(DW), .QW(QW), .OW(OW)) i_stat_srq_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .spoll_i(spoll), .wdata_i(wdata), .rdata_o(rdata), .ques_evt_i(qev),
    .std_evt_i(sev), .oper_evt_i(oev), .srq_o(srq));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #2 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [DW-1:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input logic [QW-1:0] q, input logic [7:0] s, input logic [OW-1:0] o);
    @(negedge clk);
    qev = q; sev = s; oev = o;
    @(negedge clk);
    qev = '0; sev = '0; oev = '0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), v);
      check("R10 reset reg", v, '0);
    end
    check("R10 reset srq", {15'd0, srq}, '0);
  endtask

  task automatic t_ques();
    logic [DW-1:0] v;
    wr_reg(3'd1, 16'h0004);
    rd_reg(3'd1, v);
    check("R1 qen readback", v, 16'h0004);
    pulse(5'b00001, 8'h00, '0);
    rd_reg(3'd6, v);
    check("R1 qd masked off", v & 16'h0008, 16'h0000);
    pulse(5'b00100, 8'h00, '0);
    rd_reg(3'd6, v);
    check("R1 qd set", v, 16'h0008);
    rd_reg(3'd0, v);
    check("R2 qevt read", v, 16'h0005);
    rd_reg(3'd0, v);
    check("R2 qevt not cleared", v, 16'h0005);
    wr_reg(3'd0, 16'h001f);
    rd_reg(3'd0, v);
    check("R2 qevt write ignored", v, 16'h0005);
  endtask

  task automatic t_std();
    logic [DW-1:0] v;
    wr_reg(3'd3, 16'h0010);
    rd_reg(3'd3, v);
    check("R5 sen readback", v, 16'h0010);
    pulse('0, 8'h10, '0);
    rd_reg(3'd6, v);
    check("R5 esb set", v, 16'h0028);
    rd_reg(3'd2, v);
    check("R4 sevt read", v, 16'h0010);
    rd_reg(3'd2, v);
    check("R4 sevt cleared", v, 16'h0000);
    rd_reg(3'd6, v);
    check("R5 esb cleared", v, 16'h0008);
    pulse('0, 8'h40, '0);
    @(negedge clk);
    addr = 3'd2; rd = 1'b1; sev = 8'h02;
    #2 v = rdata;
    @(negedge clk);
    rd = 1'b0; sev = 8'h00;
    check("R4 read during event", v, 16'h0040);
    rd_reg(3'd2, v);
    check("R4 same-cycle event kept", v, 16'h0002);
  endtask

  task automatic t_oper();
    logic [DW-1:0] v;
    pulse('0, 8'h00, 12'h801);
    rd_reg(3'd6, v);
    check("R3 opr masked off", v, 16'h0008);
    wr_reg(3'd5, 16'h0800);
    rd_reg(3'd6, v);
    check("R3 opr set", v, 16'h0088);
    rd_reg(3'd4, v);
    check("R3 ocnd read", v, 16'h0801);
    wr_reg(3'd4, 16'h0000);
    rd_reg(3'd4, v);
    check("R3 ocnd unchanged", v, 16'h0801);
  endtask

  task automatic t_srq();
    logic [DW-1:0] v;
    wr_reg(3'd7, 16'h0040);
    repeat (2) @(negedge clk);
    check("R6 sre bit6 ignored", {15'd0, srq}, 16'd0);
    wr_reg(3'd7, 16'h0008);
    @(negedge clk);
    check("R6 srq raised", {15'd0, srq}, 16'd1);
    rd_reg(3'd6, v);
    check("R6 rqs in stb", v, 16'h00c8);
    rd_reg(3'd6, v);
    check("R8 stb read clears nothing", v, 16'h00c8);
    @(negedge clk);
    addr = 3'd0; spoll = 1'b1;
    #2 v = rdata;
    @(negedge clk);
    spoll = 1'b0;
    check("R7 poll data", v, 16'h00c8);
    check("R7 rqs cleared", {15'd0, srq}, 16'd0);
    #2 check("R7 summaries kept", rdata, 16'h0000);
    rd_reg(3'd6, v);
    check("R9 rqs recurs", v, 16'h00c8);
    wr_reg(3'd7, 16'h0020);
    @(negedge clk);
    spoll = 1'b1;
    @(negedge clk);
    spoll = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 no recur after removal", {15'd0, srq}, 16'd0);
    rd_reg(3'd6, v);
    check("R10 unused bits zero", v & 16'h0017, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ques();
    t_std();
    t_oper();
    t_srq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule